// File: doc/BRIEF.md
# Oscillator Stabilization Wait Counter

This block times the settling period of a crystal oscillator. It runs on the oscillator clock itself, so edges only arrive once the oscillator is toggling, and any time before that is not part of the wait. It starts counting from zero when reset is released, or when a restart pulse marks the end of a low-power stop state. As the count passes each of eight uneven power-of-two marks, it sets one more bit of an 8-bit read-only status byte. The byte fills like a thermometer from its most significant bit downward.

A 3-bit select code, captured at reset or restart, picks one of the eight marks as the target wait. The count stops at that target. No status bit above the target is ever set in that run. A ready flag goes high when the target is reached, and the clock switching logic uses it to decide when the oscillator may drive the system.

Top module: `osw_wait_counter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the status byte becomes 00h, ready becomes 0 and the count becomes zero. Counting starts at the first edge after release.
- R2: With the default marks, status bit 7 is set after 2^8 edges, bit 6 after 2^9, bit 5 after 2^10, bit 4 after 2^11, bit 3 after 2^13, bit 2 after 2^15, bit 1 after 2^17 and bit 0 after 2^18. Edges are counted after the last reset or restart edge. Each mark is the parameter `EXPS[k]` for bit 7-k.
- R3: The status byte only ever holds a thermometer code that fills from bit 7 down: 00h, 80h, C0h, E0h, F0h, F8h, FCh, FEh or FFh.
- R4: A status bit that has been set stays 1 until the next reset or restart.
- R5: Select code s (0 to 7) makes mark s the target, where mark s is the one reported on status bit 7-s. Status bits for later marks stay 0 in that run.
- R6: `ready_o` rises in the same cycle as the status bit of the selected mark and stays high until the next reset or restart.
- R7: A one-cycle `restart_i` pulse clears the count, the status byte and ready at that edge. It takes priority over the increment, and counting resumes from zero on the next edge.
- R8: `sel_i` is captured only at a reset or restart edge. Changes to it between those edges have no effect on the running count.
- R9: The count saturates at the target and never wraps, so the outputs hold steady for as long as no restart arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock; the only time base |
| rst_n | input | 1 | Synchronous active-low reset |
| restart_i | input | 1 | One-cycle pulse that restarts the wait (stop-state exit) |
| sel_i | input | 3 | Target mark code, captured at reset or restart |
| stat_o | output | 8 | Thermometer status of elapsed marks, bit 7 first |
| ready_o | output | 1 | High once the selected mark has been reached |

## Verification
Every result is registered. A status bit or ready change is therefore due at exactly the edge on which the count reaches the mark, which is N edges after the reset or restart edge for a mark of N. A restart clears all outputs at the edge it is sampled on. The bench keeps a behavioural count that it advances on each rising edge from the same inputs, and compares the outputs on the following falling edge, so each output is checked in the cycle it is due. The bench overrides the mark exponents with small values so that every select code can be run to saturation.

// File: rtl/osw_pkg.sv
// Package: shared constants and types of the oscillator stabilization wait counter.
// Assumes exactly eight marks, so a 3-bit select code covers them all.
package osw_pkg;
    localparam int OSW_STEPS = 8;
    localparam int SEL_W     = 3;
    typedef logic [OSW_STEPS-1:0] osw_stat_t;
    localparam int unsigned OSW_DEF_EXPS [OSW_STEPS] = '{8, 9, 10, 11, 13, 15, 17, 18};
endpackage

// File: rtl/osw_count.sv
// Module: saturating up-counter of oscillator edges.
// Captures the select code at reset or restart. It counts one per edge until the
// count equals 2^EXPS[select], and then holds. Assumes EXPS is ascending.
module osw_count
    import osw_pkg::*;
#(
    parameter int unsigned EXPS [OSW_STEPS] = OSW_DEF_EXPS,
    localparam int CNT_W = EXPS[OSW_STEPS-1] + 1
) (
    input  logic             osc_clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [CNT_W-1:0] cnt_nxt_o,
    output logic             step_o,
    output logic [SEL_W-1:0] sel_q_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_arr [OSW_STEPS];
    logic [CNT_W-1:0] limit;

    // Limit value of each mark
    for (genvar k = 0; k < OSW_STEPS; k++) begin : g_lim
        assign lim_arr[k] = CNT_W'(1) << EXPS[k];
    end

    // Target of the current run and the advance decision
    always_comb begin
        limit     = lim_arr[sel_q_o];
        step_o    = !restart_i && (cnt_q != limit);
        cnt_nxt_o = cnt_q + CNT_W'(1);
    end

    // Count register and select capture; restart wins over increment
    always_ff @(posedge osc_clk) begin
        if (!rst_n || restart_i) begin
            cnt_q   <= '0;
            sel_q_o <= sel_i;
        end else if (step_o) begin
            cnt_q <= cnt_nxt_o;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge osc_clk) disable iff (!rst_n)
        cnt_q <= limit);                                                        // R9
    AST_RESTART_CLEAR: assert property (@(posedge osc_clk) disable iff (!rst_n)
        restart_i |=> cnt_q == '0);                                             // R7
    AST_SEL_HELD: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !restart_i |=> $stable(sel_q_o));                                       // R8
endmodule

// File: rtl/osw_thermo.sv
// Module: sticky thermometer status and ready flag.
// Sets status bit 7-k on the edge at which the count reaches mark k, and raises
// ready on the edge at which the selected mark is reached. Assumes eight marks,
// so that the bit of select code s is ~s.
module osw_thermo
    import osw_pkg::*;
#(
    parameter int unsigned EXPS [OSW_STEPS] = OSW_DEF_EXPS,
    localparam int CNT_W = EXPS[OSW_STEPS-1] + 1
) (
    input  logic             osc_clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] cnt_nxt_i,
    input  logic [SEL_W-1:0] sel_q_i,
    output osw_stat_t        stat_o,
    output logic             ready_o
);
    osw_stat_t        hit_v;
    logic [SEL_W-1:0] tgt_bit;

    // Mark hits of this edge, placed on their status bit positions
    for (genvar k = 0; k < OSW_STEPS; k++) begin : g_hit
        assign hit_v[OSW_STEPS-1-k] = step_i && (cnt_nxt_i == (CNT_W'(1) << EXPS[k]));
    end

    // Status bit position of the selected mark
    assign tgt_bit = ~sel_q_i;

    // Sticky status bits and ready flag
    always_ff @(posedge osc_clk) begin
        if (!rst_n || restart_i) begin
            stat_o  <= '0;
            ready_o <= 1'b0;
        end else begin
            stat_o  <= stat_o | hit_v;
            ready_o <= ready_o | hit_v[tgt_bit];
        end
    end

    AST_THERMO_CODE: assert property (@(posedge osc_clk) disable iff (!rst_n)
        stat_o == osw_stat_t'({OSW_STEPS{1'b1}} << (OSW_STEPS - $countones(stat_o)))); // R3
    AST_STICKY: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !restart_i |=> (stat_o & $past(stat_o)) == $past(stat_o));              // R4
    AST_NO_BEYOND: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (stat_o & ((osw_stat_t'(1) << tgt_bit) - osw_stat_t'(1))) == '0);       // R5
    AST_READY_MATCH: assert property (@(posedge osc_clk) disable iff (!rst_n)
        ready_o == stat_o[tgt_bit]);                                            // R6
    AST_CLEAR_ON_RESTART: assert property (@(posedge osc_clk) disable iff (!rst_n)
        restart_i |=> (stat_o == '0) && !ready_o);                              // R7
endmodule

// File: rtl/osw_wait_counter.sv
// Module: top of the oscillator stabilization wait counter.
// Joins the saturating counter to the thermometer status stage. Everything runs
// on the oscillator clock, so time before the first oscillator edge is not counted.
module osw_wait_counter
    import osw_pkg::*;
#(
    parameter int unsigned EXPS [OSW_STEPS] = OSW_DEF_EXPS,
    localparam int CNT_W = EXPS[OSW_STEPS-1] + 1
) (
    input  logic             osc_clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [OSW_STEPS-1:0] stat_o,
    output logic             ready_o
);
    logic [CNT_W-1:0] cnt_nxt;
    logic             step;
    logic [SEL_W-1:0] sel_q;

    osw_count #(.EXPS(EXPS)) u_count (
        .osc_clk   (osc_clk),
        .rst_n     (rst_n),
        .restart_i (restart_i),
        .sel_i     (sel_i),
        .cnt_nxt_o (cnt_nxt),
        .step_o    (step),
        .sel_q_o   (sel_q)
    );

    osw_thermo #(.EXPS(EXPS)) u_thermo (
        .osc_clk   (osc_clk),
        .rst_n     (rst_n),
        .restart_i (restart_i),
        .step_i    (step),
        .cnt_nxt_i (cnt_nxt),
        .sel_q_i   (sel_q),
        .stat_o    (stat_o),
        .ready_o   (ready_o)
    );

    AST_READY_HOLD: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (ready_o && !restart_i) |=> ready_o);                                   // R6
endmodule

// File: tb/osw_wait_counter_bench.sv
// Bench: a behavioural edge count is compared with the outputs on every falling edge.
module osw_wait_counter_bench;
    localparam int unsigned TB_EXPS [8] = '{2, 3, 4, 5, 6, 7, 8, 9};

    logic       osc_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       restart_i = 1'b0;
    logic [2:0] sel_i = 3'd0;
    logic [7:0] stat_o;
    logic       ready_o;

    int checks = 0;
    int failures = 0;
    int exp_n = 0;
    int exp_sel = 0;
    bit model_on = 1'b0;
    string phase = "R1";

    osw_wait_counter #(.EXPS(TB_EXPS)) u_osw_wait_counter (
        .osc_clk(osc_clk), .rst_n(rst_n), .restart_i(restart_i),
        .sel_i(sel_i), .stat_o(stat_o), .ready_o(ready_o)
    );

    always #2.5 osc_clk = ~osc_clk;

    function automatic int mark(input int k);
        return 1 << TB_EXPS[k];
    endfunction

    function automatic logic [7:0] exp_stat(input int n);
        logic [7:0] s = '0;
        for (int k = 0; k < 8; k++) if (n >= mark(k)) s[7-k] = 1'b1;
        return s;
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Behavioural model of the edge count
    always @(posedge osc_clk) begin
        if (!rst_n || restart_i) begin
            exp_n   <= 0;
            exp_sel <= int'(sel_i);
        end else if (exp_n < mark(exp_sel)) begin
            exp_n <= exp_n + 1;
        end
    end

    // Comparison each cycle, away from the active edge
    always @(negedge osc_clk) begin
        if (model_on) begin
            check({phase, " stat"}, {1'b0, stat_o}, {1'b0, exp_stat(exp_n)});
            check({phase, " ready"}, {8'd0, ready_o}, {8'd0, exp_n == mark(exp_sel)});
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge osc_clk);
    endtask

    task automatic do_restart(input logic [2:0] s);
        sel_i = s;
        restart_i = 1'b1;
        cycles(1);
        restart_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge osc_clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
        $finish;
    end

    initial begin
        // R1: reset state
        sel_i = 3'd7;
        cycles(3);
        check("R1 reset stat", {1'b0, stat_o}, 9'h000);
        check("R1 reset ready", {8'd0, ready_o}, 9'h000);
        model_on = 1'b1;
        rst_n = 1'b1;
        // R2 R3 R4, with R8: the select changes after capture
        phase = "R2 R8";
        cycles(50);
        sel_i = 3'd0;
        cycles(480);
        check("R2 all bits", {1'b0, stat_o}, 9'h0FF);
        check("R9 saturated ready", {8'd0, ready_o}, 9'h001);
        // R5 R6 R9: every select code run to saturation and held
        for (int s = 0; s < 8; s++) begin
            phase = "R5 R6";
            do_restart(3'(s));
            cycles(mark(s) + 6);
            check("R5 final stat", {1'b0, stat_o}, {1'b0, exp_stat(mark(s))});
            check("R6 ready held", {8'd0, ready_o}, 9'h001);
        end
        // R7: a restart during an active count
        phase = "R7";
        do_restart(3'd4);
        cycles(40);
        restart_i = 1'b1;
        sel_i = 3'd1;
        cycles(1);
        restart_i = 1'b0;
        check("R7 cleared", {ready_o, stat_o}, 9'h000);
        cycles(20);
        check("R7 after", {ready_o, stat_o}, 9'h1C0);
        // R1: a reset during an active count
        phase = "R1";
        do_restart(3'd6);
        cycles(30);
        rst_n = 1'b0;
        sel_i = 3'd2;
        cycles(1);
        check("R1 mid reset", {ready_o, stat_o}, 9'h000);
        rst_n = 1'b1;
        cycles(40);
        check("R1 restart count", {ready_o, stat_o}, 9'h1E0);
        report();
        $finish;
    end
endmodule